// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block decides which interrupt request the processor should take next. It holds a pending flag for each of a configurable number of interrupt lines. Each line has a programmable priority byte and an enable bit. A split setting divides the priority bits into a preemption part and a sub-priority part. A base mask blocks requests of lower urgency. Three system exceptions with fixed priorities outrank every line and bypass both the enable bits and the mask. The arbiter compares the best eligible request with the level of the handler now running. When the request is more urgent, it raises a one-cycle take strobe.

On a take, the block pushes the running level onto an internal level stack, and the new handler's preemption level becomes the active level. When the handler returns, the previous level is popped back. The stack is sized from the number of distinct levels, so it cannot overflow. Configuration goes through a small select/index/data write port. A registered read path returns the stored values.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset, nothing is pending, all lines are disabled, all priorities are 0, the split is 0, the mask is 0, the active level is 63 (idle) and take is low.
- R2: A priority write (select 0, index = line) stores only data bits [7:4]. The read-back returns those bits in [7:4], with [3:0] always zero. Read data appears one cycle after select and index are presented.
- R3: A pending line whose enable bit (select 1, data bit 0) is clear is never taken. Setting the enable later lets it be taken.
- R4: Among eligible lines, the lowest full 4-bit priority wins. A tie on the full priority is won by the lowest line index.
- R5: A line preempts only if its preemption field is numerically lower than the preemption field of the running handler. The preemption field is the priority with its low split bits cleared. Sub-priority alone never preempts.
- R6: The split register (select 2) holds the number of sub-priority bits, 0 to 4. A write above 4 is stored as 4.
- R7: A nonzero mask (select 3, data bits [7:4]) blocks every line whose priority is greater than or equal to the mask. A mask of zero blocks nothing.
- R8: The system exceptions (sys_req bit 0 = reset, bit 1 = non-maskable, bit 2 = hard fault) report win_id N, N+1 and N+2 and take levels 0, 1 and 2. They ignore the enable bits and the mask, and they outrank every line.
- R9: take is combinational and lasts a single cycle per taken request. The taken request's pending flag clears on the next edge, and act_level shows the new level from that edge onward.
- R10: A handler return restores the level that was active before the matching take. take is held low during any cycle in which handler_ret is high. A return with no handler active is ignored.
- R11: act_level encoding: 0, 1 and 2 for the system exceptions, 3 plus the preemption field for a line, and 63 when no handler runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 priority, 1 enable, 2 split, 3 mask |
| cfg_idx | input | 3 | Line index for priority/enable |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data for sel/idx |
| irq_req | input | 8 | Per-line request pulses, set pending |
| sys_req | input | 3 | System exception requests |
| handler_ret | input | 1 | Running handler returns |
| take | output | 1 | Take-interrupt strobe |
| win_id | output | 4 | Winning request index (lines 0..7, system 8..10) |
| act_level | output | 6 | Active preemption level |

## Verification
On every cycle, the checker confirms the following. A taken line was enabled and was not blocked by the mask. A pending system exception always beats a line. Each take makes the active level strictly more urgent, and each return makes it strictly less urgent. A taken pending flag clears unless it is requested again. The stack never exceeds its depth, and an empty stack means the idle level. Only the bench sweeps can show which request actually wins. That covers the argmin order with ties, the preemption decision under all five splits and all priority pairs, the mask threshold across every value, register read-back and clamping, and the exact levels restored through nested returns.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int FIELD_W = 8;
  localparam int NUM_SYS = 3;
  typedef enum logic [1:0] {
    CFG_PRIO  = 2'd0,
    CFG_EN    = 2'd1,
    CFG_SPLIT = 2'd2,
    CFG_MASK  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int N_LINES   = 8,
  parameter int PRIO_BITS = 4,
  parameter int IDX_W     = 3,
  parameter int SB_W      = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [1:0]                         sel,
  input  logic [IDX_W-1:0]                   idx,
  input  logic [FIELD_W-1:0]                 wdata,
  output logic [FIELD_W-1:0]                 rdata,
  output logic [N_LINES-1:0][PRIO_BITS-1:0]  prio_o,
  output logic [N_LINES-1:0]                 en_o,
  output logic [SB_W-1:0]                    sub_bits_o,
  output logic [PRIO_BITS-1:0]               mask_o
);
  localparam int LOW_W = FIELD_W - PRIO_BITS;

  logic [PRIO_BITS-1:0] hi_bits;
  logic                 idx_ok;
  assign hi_bits = wdata[FIELD_W-1:LOW_W];
  assign idx_ok  = (32'(idx) < N_LINES);

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_o     <= '0;
      en_o       <= '0;
      sub_bits_o <= '0;
      mask_o     <= '0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        CFG_PRIO:  if (idx_ok) prio_o[idx] <= hi_bits;
        CFG_EN:    if (idx_ok) en_o[idx] <= wdata[0];
        CFG_SPLIT: sub_bits_o <= (32'(wdata) > PRIO_BITS) ? SB_W'(PRIO_BITS) : SB_W'(wdata);
        default:   mask_o <= hi_bits;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (cfg_sel_e'(sel))
        CFG_PRIO:  rdata <= idx_ok ? {prio_o[idx], {LOW_W{1'b0}}} : '0;
        CFG_EN:    rdata <= idx_ok ? FIELD_W'(en_o[idx]) : '0;
        CFG_SPLIT: rdata <= FIELD_W'(sub_bits_o);
        default:   rdata <= {mask_o, {LOW_W{1'b0}}};
      endcase
    end
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
#(
  parameter int N_LINES   = 8,
  parameter int PRIO_BITS = 4,
  parameter int ID_W      = 4,
  parameter int LV_W      = 6,
  parameter int SB_W      = 3
) (
  input  logic [N_LINES-1:0]                pend,
  input  logic [N_LINES-1:0]                en,
  input  logic [N_LINES-1:0][PRIO_BITS-1:0] prio,
  input  logic [SB_W-1:0]                   sub_bits,
  input  logic [PRIO_BITS-1:0]              mask,
  input  logic [NUM_SYS-1:0]                sys_pend,
  input  logic [LV_W-1:0]                   act_level,
  output logic                              win_ok,
  output logic [ID_W-1:0]                   win_id,
  output logic [LV_W-1:0]                   win_level
);
  logic [N_LINES-1:0]   elig;
  logic [PRIO_BITS-1:0] pmask;
  logic [PRIO_BITS-1:0] best_prio;
  logic [ID_W-1:0]      best_i;
  logic                 found;

  for (genvar g = 0; g < N_LINES; g++) begin : g_elig
    assign elig[g] = pend[g] && en[g] && !((mask != '0) && (prio[g] >= mask));
  end

  always_comb begin
    pmask     = {PRIO_BITS{1'b1}} << sub_bits;
    found     = 1'b0;
    best_prio = '1;
    best_i    = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (elig[i] && (!found || prio[i] < best_prio)) begin
        found     = 1'b1;
        best_prio = prio[i];
        best_i    = ID_W'(i);
      end
    end
    win_id    = best_i;
    win_level = found ? (LV_W'(best_prio & pmask) + LV_W'(NUM_SYS)) : '1;
    for (int k = NUM_SYS - 1; k >= 0; k--) begin
      if (sys_pend[k]) begin
        win_id    = ID_W'(N_LINES + k);
        win_level = LV_W'(k);
      end
    end
    win_ok = ((|sys_pend) || found) && (win_level < act_level);
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
  parameter int LV_W  = 6,
  parameter int DEPTH = 19,
  parameter int SP_W  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [LV_W-1:0] push_level,
  input  logic            pop,
  output logic [LV_W-1:0] act_level,
  output logic [SP_W-1:0] sp
);
  logic [LV_W-1:0] mem [DEPTH];
  logic            do_pop;

  assign do_pop = pop && (sp != '0);

  always_ff @(posedge clk) begin
    if (push) mem[sp] <= act_level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_level <= '1;
      sp        <= '0;
    end else if (push) begin
      act_level <= push_level;
      sp        <= sp + SP_W'(1);
    end else if (do_pop) begin
      act_level <= mem[sp - SP_W'(1)];
      sp        <= sp - SP_W'(1);
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int N_LINES   = 8,
  parameter int PRIO_BITS = 4,
  localparam int IDX_W    = $clog2(N_LINES),
  localparam int ID_W     = $clog2(N_LINES + NUM_SYS),
  localparam int LV_W     = PRIO_BITS + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [FIELD_W-1:0]   cfg_wdata,
  output logic [FIELD_W-1:0]   cfg_rdata,
  input  logic [N_LINES-1:0]   irq_req,
  input  logic [NUM_SYS-1:0]   sys_req,
  input  logic                 handler_ret,
  output logic                 take,
  output logic [ID_W-1:0]      win_id,
  output logic [LV_W-1:0]      act_level
);
  localparam int SB_W  = $clog2(PRIO_BITS + 1);
  localparam int DEPTH = NUM_SYS + (1 << PRIO_BITS);
  localparam int SP_W  = $clog2(DEPTH + 1);

  logic [N_LINES-1:0][PRIO_BITS-1:0] prio_q;
  logic [N_LINES-1:0]                en_q;
  logic [SB_W-1:0]                   sub_bits_q;
  logic [PRIO_BITS-1:0]              mask_q;
  logic [N_LINES-1:0]                pend_q, clr_line;
  logic [NUM_SYS-1:0]                sys_q, clr_sys;
  logic                              win_ok;
  logic [LV_W-1:0]                   win_level;
  logic [SP_W-1:0]                   sp_q;

  irq_cfg_regs #(.N_LINES(N_LINES), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W), .SB_W(SB_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .idx(cfg_idx), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .prio_o(prio_q), .en_o(en_q), .sub_bits_o(sub_bits_q), .mask_o(mask_q)
  );

  irq_select #(.N_LINES(N_LINES), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W), .LV_W(LV_W), .SB_W(SB_W)) u_sel (
    .pend(pend_q), .en(en_q), .prio(prio_q), .sub_bits(sub_bits_q), .mask(mask_q),
    .sys_pend(sys_q), .act_level(act_level), .win_ok(win_ok), .win_id(win_id), .win_level(win_level)
  );

  assign take = win_ok && !handler_ret;

  for (genvar g = 0; g < N_LINES; g++) begin : g_clr
    assign clr_line[g] = take && (win_id == ID_W'(g));
  end
  for (genvar k = 0; k < NUM_SYS; k++) begin : g_clrs
    assign clr_sys[k] = take && (win_id == ID_W'(N_LINES + k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      sys_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_line) | irq_req;
      sys_q  <= (sys_q & ~clr_sys) | sys_req;
    end
  end

  irq_level_stack #(.LV_W(LV_W), .DEPTH(DEPTH), .SP_W(SP_W)) u_stack (
    .clk(clk), .rst(rst), .push(take), .push_level(win_level), .pop(handler_ret),
    .act_level(act_level), .sp(sp_q)
  );
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int N_LINES   = 8,
  parameter int PRIO_BITS = 4,
  localparam int ID_W     = $clog2(N_LINES + 3),
  localparam int LV_W     = PRIO_BITS + 2,
  localparam int DEPTH    = 3 + (1 << PRIO_BITS),
  localparam int SP_W     = $clog2(DEPTH + 1)
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                take,
  input logic                                handler_ret,
  input logic [ID_W-1:0]                     win_id,
  input logic [LV_W-1:0]                     act_level,
  input logic [N_LINES-1:0]                  irq_req,
  input logic [N_LINES-1:0]                  pend_q,
  input logic [N_LINES-1:0]                  en_q,
  input logic [N_LINES-1:0][PRIO_BITS-1:0]   prio_q,
  input logic [PRIO_BITS-1:0]                mask_q,
  input logic [2:0]                          sys_q,
  input logic [SP_W-1:0]                     sp_q
);
  AST_EN_REQUIRED: assert property (@(posedge clk) disable iff (rst)
    (take && 32'(win_id) < N_LINES) |-> en_q[win_id]); // R3
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (take && 32'(win_id) < N_LINES && mask_q != '0) |-> (prio_q[win_id] < mask_q)); // R7
  AST_SYS_FIRST: assert property (@(posedge clk) disable iff (rst)
    (take && sys_q != '0) |-> (32'(win_id) >= N_LINES)); // R8
  AST_TAKE_RAISES: assert property (@(posedge clk) disable iff (rst)
    take |=> (act_level < $past(act_level))); // R5
  AST_RET_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (handler_ret && sp_q != '0) |=> (act_level > $past(act_level))); // R10
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (take && 32'(win_id) < N_LINES) |=> (!pend_q[$past(win_id)] || $past(irq_req[win_id]))); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    32'(sp_q) <= DEPTH); // R10
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (sp_q == '0) |-> (act_level == '1)); // R11
endmodule

bind irq_prio_arb irq_arb_chk #(.N_LINES(N_LINES), .PRIO_BITS(PRIO_BITS)) u_chk (
  .clk(clk), .rst(rst), .take(take), .handler_ret(handler_ret), .win_id(win_id),
  .act_level(act_level), .irq_req(irq_req), .pend_q(pend_q), .en_q(en_q), .prio_q(prio_q),
  .mask_q(mask_q), .sys_q(sys_q), .sp_q(sp_q)
);

// File: tb/irq_prio_arb_tb.sv
`timescale 1ns/1ps
module irq_prio_arb_tb;
  localparam int N = 8;
  localparam int IDLE = 63;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [2:0] cfg_idx = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [7:0] irq_req = '0;
  logic [2:0] sys_req = '0;
  logic       handler_ret = 1'b0;
  logic       take;
  logic [3:0] win_id;
  logic [5:0] act_level;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_arb u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req), .sys_req(sys_req),
    .handler_ret(handler_ret), .take(take), .win_id(win_id), .act_level(act_level)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int idx, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_idx = 3'(idx); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int sel, input int idx, output int data);
    @(negedge clk);
    cfg_sel = 2'(sel); cfg_idx = 3'(idx);
    @(negedge clk);
    #1 data = int'(cfg_rdata);
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk);
    irq_req = v;
    @(negedge clk);
    irq_req = '0;
    #1;
  endtask

  task automatic psys(input logic [2:0] v);
    @(negedge clk);
    sys_req = v;
    @(negedge clk);
    sys_req = '0;
    #1;
  endtask

  task automatic ret();
    @(negedge clk);
    handler_ret = 1'b1;
    @(negedge clk);
    handler_ret = 1'b0;
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) ret();
    @(negedge clk);
    #1;
  endtask

  function automatic int pm_of(input int s);
    return (15 << s) & 15;
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(take == 1'b0, "R1 take", int'(take), 0);
    chk(int'(act_level) == IDLE, "R1 act_level", int'(act_level), IDLE);
    for (int i = 0; i < N; i++) begin
      rd(0, i, d); chk(d == 0, "R1 prio", d, 0);
      rd(1, i, d); chk(d == 0, "R1 enable", d, 0);
    end
    rd(2, 0, d); chk(d == 0, "R1 split", d, 0);
    rd(3, 0, d); chk(d == 0, "R1 mask", d, 0);

    // R2 priority read-back with low bits forced to zero
    for (int i = 0; i < N; i++) begin
      wr(0, i, (i * 37 + 5) & 255);
      rd(0, i, d);
      chk(d == ((i * 37 + 5) & 240), "R2 prio readback", d, (i * 37 + 5) & 240);
    end

    // R6 split clamping
    for (int v = 0; v < 8; v++) begin
      wr(2, 0, v);
      rd(2, 0, d);
      chk(d == ((v > 4) ? 4 : v), "R6 split", d, (v > 4) ? 4 : v);
    end
    wr(2, 0, 0);

    // R3 enable gating
    wr(0, 5, 8'h30);
    pulse(8'h20);
    chk(take == 1'b0, "R3 disabled line", int'(take), 0);
    @(negedge clk); #1;
    chk(take == 1'b0, "R3 still blocked", int'(take), 0);
    wr(1, 5, 1);
    #1;
    chk(take == 1'b1 && win_id == 4'd5, "R3 enabled take", int'(win_id), 5);
    @(negedge clk); #1;
    chk(int'(act_level) == 6, "R11 level line", int'(act_level), 6);
    chk(take == 1'b0, "R9 single strobe", int'(take), 0);
    drain(2);
    chk(int'(act_level) == IDLE, "R10 back to idle", int'(act_level), IDLE);

    for (int i = 0; i < N; i++) wr(1, i, 1);

    // R7 mask threshold sweep
    for (int m = 0; m < 16; m++) begin
      wr(3, 0, m << 4);
      for (int p = 0; p < 16; p++) begin
        wr(0, 0, p << 4);
        pulse(8'h01);
        chk(take == ((m == 0) || (p < m)), "R7 mask", int'(take), int'((m == 0) || (p < m)));
        if (!take) wr(3, 0, 0);
        drain(2);
        if (m != 0) wr(3, 0, m << 4);
      end
    end
    wr(3, 0, 0);
    chk(int'(act_level) == IDLE, "R7 idle after sweep", int'(act_level), IDLE);

    // R5 preemption vs split, all priority pairs
    for (int s = 0; s < 5; s++) begin
      wr(2, 0, s);
      for (int a = 0; a < 16; a++) begin
        wr(0, 0, a << 4);
        for (int b = 0; b < 16; b++) begin
          wr(0, 1, b << 4);
          pulse(8'h01);
          chk(take == 1'b1 && win_id == 4'd0, "R5 first take", int'(win_id), 0);
          @(negedge clk); #1;
          chk(int'(act_level) == 3 + (a & pm_of(s)), "R11 active level", int'(act_level),
              3 + (a & pm_of(s)));
          pulse(8'h02);
          chk(take == ((b & pm_of(s)) < (a & pm_of(s))), "R5 preempt decision", int'(take),
              int'((b & pm_of(s)) < (a & pm_of(s))));
          drain(4);
          chk(int'(act_level) == IDLE, "R10 drained", int'(act_level), IDLE);
        end
      end
    end

    // R4 argmin with ties broken by lowest index
    for (int s = 0; s < 3; s += 2) begin
      wr(2, 0, s);
      for (int k = 1; k <= 8; k++) begin
        for (int c = 0; c < 2; c++) begin
          int bp, bi;
          bp = 99; bi = 0;
          for (int i = 0; i < N; i++) begin
            int p;
            p = (i * k + c * 5 + k) % 16;
            wr(0, i, p << 4);
            if (p < bp) begin bp = p; bi = i; end
          end
          pulse(8'hFF);
          chk(take == 1'b1 && int'(win_id) == bi, "R4 winner", int'(win_id), bi);
          drain(10);
        end
      end
    end
    wr(2, 0, 0);

    // R8 system exceptions: nesting, mask and enable ignored
    for (int i = 0; i < N; i++) wr(1, i, 0);
    wr(3, 0, 8'h10);
    psys(3'b100);
    chk(take == 1'b1 && int'(win_id) == N + 2, "R8 hard fault id", int'(win_id), N + 2);
    @(negedge clk); #1;
    chk(int'(act_level) == 2, "R8 hard fault level", int'(act_level), 2);
    psys(3'b010);
    chk(take == 1'b1 && int'(win_id) == N + 1, "R8 nmi preempts", int'(win_id), N + 1);
    @(negedge clk); #1;
    chk(int'(act_level) == 1, "R8 nmi level", int'(act_level), 1);
    psys(3'b001);
    chk(take == 1'b1 && int'(win_id) == N, "R8 reset preempts", int'(win_id), N);
    @(negedge clk); #1;
    chk(int'(act_level) == 0, "R8 reset level", int'(act_level), 0);
    psys(3'b100);
    chk(take == 1'b0, "R8 hard fault waits", int'(take), 0);
    ret(); #1;
    chk(int'(act_level) == 1, "R10 restore nmi", int'(act_level), 1);
    ret(); #1;
    chk(int'(act_level) == 2, "R10 restore hard fault", int'(act_level), 2);
    drain(4);
    chk(int'(act_level) == IDLE, "R8 idle", int'(act_level), IDLE);
    wr(1, 3, 1);
    wr(0, 3, 8'h00);
    @(negedge clk);
    irq_req = 8'h08; sys_req = 3'b010;
    @(negedge clk);
    irq_req = '0; sys_req = '0;
    #1;
    chk(take == 1'b1 && int'(win_id) == N + 1, "R8 outranks line", int'(win_id), N + 1);
    drain(4);
    wr(3, 0, 0);

    // R10 empty return ignored, take held off while returning
    ret(); #1;
    chk(int'(act_level) == IDLE, "R10 empty return", int'(act_level), IDLE);
    @(negedge clk);
    handler_ret = 1'b1; irq_req = 8'h08;
    @(negedge clk);
    irq_req = '0;
    #1;
    chk(take == 1'b0, "R10 take held", int'(take), 0);
    @(negedge clk);
    handler_ret = 1'b0;
    #1;
    chk(take == 1'b1 && win_id == 4'd3, "R10 take after return", int'(win_id), 3);
    drain(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule